// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block sits between a host processor and the core of a display controller. One set of pins serves three bus styles. A strap picks parallel or serial operation. In parallel operation, a second strap picks between a 6800-style bus, which uses an enable pulse plus a read/write level, and an 8080-style bus, which uses separate active-low read and write strobes. The serial mode is write-only: data bit 7 of the bus carries the serial data and data bit 6 carries the serial clock.

Every pin is brought into the system clock domain through a synchronizer chain. Each completed transfer then appears as a pulse one clock wide on `xfer_vld`. The pulse carries the byte, a data/command flag and a read/write flag. During a parallel read, the block drives `db_out` and raises `db_oe`. The pad tristate driver outside the block uses `db_oe`. With register select low, a read returns a status byte that holds the core's busy flag. With register select high, a read returns the display byte that the core presents on `rd_data`.

The block responds only while the active-low select is low and the active-high select is high. Taking the chip out of that state also throws away any partly received serial byte.

Top module: `host_bus_bridge`

## Requirements
- R1: No transfer is reported and `db_oe` stays low unless `cs_n`=0 and `cs`=1. Strobes, register select and data arriving while deselected have no effect.
- R2: When `mode_par`=1 and `mode_68`=1, a falling edge of `en_rd` with `rw_wr`=0 reports a write (`xfer_rd`=0). The byte reported is the one on `db_in` at that edge.
- R3: When `mode_par`=1 and `mode_68`=1, the block drives the bus (`db_oe`=1) while `en_rd`=1 and `rw_wr`=1. A rising edge of `en_rd` with `rw_wr`=1 reports one read (`xfer_rd`=1).
- R4: When `mode_par`=1 and `mode_68`=0, a rising edge of the active-low write strobe `rw_wr` reports a write. The byte reported is the one on `db_in` at that edge.
- R5: When `mode_par`=1 and `mode_68`=0, the block drives the bus while the active-low read strobe `en_rd` is low. Its falling edge reports one read.
- R6: `xfer_dc` equals `rs`. A read with `rs`=0 returns the status byte {busy, 7'b0000000}. A read with `rs`=1 returns `rd_data`. The reported byte of a read equals the value driven on `db_out`.
- R7: When `mode_par`=0, serial bits are taken from `db_in[7]` on each rising edge of `db_in[6]`, most significant bit first. The eighth edge reports the byte as a write, with `xfer_dc` equal to `rs` at that edge. In this mode `db_oe` stays low and the parallel strobes have no effect.
- R8: Deselecting the chip clears the serial bit counter and the partial byte. The next byte is built only from bits received after reselection.
- R9: While `busy`=1, writes (parallel or serial) and data reads report nothing. Status reads are still reported.
- R10: Each transfer produces exactly one pulse, one clock wide, on `xfer_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| mode_par | input | 1 | 1 = parallel bus, 0 = serial write-only |
| mode_68 | input | 1 | 1 = 6800 style, 0 = 8080 style (parallel only) |
| rs | input | 1 | 1 = display data, 0 = control/status |
| en_rd | input | 1 | 6800: enable E; 8080: active-low read strobe |
| rw_wr | input | 1 | 6800: read(1)/write(0); 8080: active-low write strobe |
| db_in | input | 8 | Data bus as seen at the pads; in serial mode, bit 7 carries data and bit 6 carries the clock |
| db_out | output | 8 | Byte driven toward the bus during a read |
| db_oe | output | 1 | Output enable for the data bus pad drivers |
| busy | input | 1 | Core busy flag |
| rd_data | input | 8 | Display byte supplied by the core for data reads |
| xfer_vld | output | 1 | One-cycle pulse for each accepted transfer |
| xfer_byte | output | 8 | Byte written or read |
| xfer_dc | output | 1 | 1 = display data, 0 = command/status |
| xfer_rd | output | 1 | 1 = read, 0 = write |

## Verification
The hardest case to reach is a serial byte that is cut off part-way. Three bits are clocked in, the chip is deselected for a few cycles, and then a full byte follows. If any stale bit or count survived, the reported byte would differ from the new one. The busy gating is also hard to see, because the only evidence is a pulse that never appears. The bench therefore holds `busy` high across a parallel write, a data read, a status read and a whole serial byte. Its scoreboard flags any pulse it did not expect, and it also flags any expected item still left in the queue at the end.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic [DW-1:0] dat;
    logic          dc;
    logic          rd;
  } hbus_xfer_t;

  // status byte: busy flag in the top bit, remaining bits zero
  function automatic logic [DW-1:0] status_byte(input logic busy_f);
    return {busy_f, {(DW-1){1'b0}}};
  endfunction

  // an access is accepted when idle, or when it is a status read
  function automatic logic accept(input logic busy_f, input logic is_rd, input logic is_dat);
    return !busy_f || (is_rd && !is_dat);
  endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_par.sv
module hbus_par import hbus_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          m68,
  input  logic          rs,
  input  logic          en_rd,
  input  logic          rw_wr,
  input  logic [DW-1:0] db,
  input  logic          busy,
  input  logic [DW-1:0] rd_byte,
  output logic          evt_vld,
  output hbus_xfer_t    evt,
  output logic          oe,
  output logic [DW-1:0] dout
);
  logic en_q, rw_q;
  logic rd_phase, rd_evt, wr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      rw_q <= 1'b0;
    end else begin
      en_q <= en_rd;
      rw_q <= rw_wr;
    end
  end

  always_comb begin
    if (m68) begin
      rd_phase = en_rd && rw_wr;
      rd_evt   = sel && rw_wr && en_rd && !en_q;
      wr_evt   = sel && !rw_wr && en_q && !en_rd;
    end else begin
      rd_phase = !en_rd;
      rd_evt   = sel && en_q && !en_rd;
      wr_evt   = sel && !rw_q && rw_wr;
    end
  end

  assign dout    = rs ? rd_byte : status_byte(busy);
  assign oe      = sel && rd_phase;
  assign evt_vld = (rd_evt && accept(busy, 1'b1, rs)) ||
                   (wr_evt && accept(busy, 1'b0, rs));
  assign evt.dat = rd_evt ? dout : db;
  assign evt.dc  = rs;
  assign evt.rd  = rd_evt;
endmodule

// File: rtl/hbus_ser.sv
module hbus_ser import hbus_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       rs,
  input  logic       sclk,
  input  logic       sdat,
  input  logic       busy,
  output logic       evt_vld,
  output hbus_xfer_t evt
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-2:0] sh;
  logic [CW-1:0] cnt;
  logic          sclk_q;
  logic          rise, last_bit;

  assign rise     = sel && sclk && !sclk_q;
  assign last_bit = rise && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (!sel) begin
        sh  <= '0;
        cnt <= '0;
      end else if (rise) begin
        sh  <= last_bit ? '0 : {sh[DW-3:0], sdat};
        cnt <= last_bit ? '0 : cnt + 1'b1;
      end
    end
  end

  assign evt_vld = last_bit && accept(busy, 1'b0, rs);
  assign evt.dat = {sh, sdat};
  assign evt.dc  = rs;
  assign evt.rd  = 1'b0;

  // R8: a deselected cycle leaves the counter empty
  a_r8_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt == '0));
endmodule

// File: rtl/host_bus_bridge.sv
module host_bus_bridge import hbus_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cs,
  input  logic          mode_par,
  input  logic          mode_68,
  input  logic          rs,
  input  logic          en_rd,
  input  logic          rw_wr,
  input  logic [DW-1:0] db_in,
  output logic [DW-1:0] db_out,
  output logic          db_oe,
  input  logic          busy,
  input  logic [DW-1:0] rd_data,
  output logic          xfer_vld,
  output logic [DW-1:0] xfer_byte,
  output logic          xfer_dc,
  output logic          xfer_rd
);
  localparam int CTLW = 7;
  localparam int SW   = CTLW + DW;

  logic [SW-1:0] raw, syn;
  logic cs_n_s, cs_s, par_s, m68_s, rs_s, en_s, rw_s;
  logic [DW-1:0] db_s;
  logic sel_s, sel_par, sel_ser;

  assign raw = {cs_n, cs, mode_par, mode_68, rs, en_rd, rw_wr, db_in};

  hbus_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign {cs_n_s, cs_s, par_s, m68_s, rs_s, en_s, rw_s, db_s} = syn;
  assign sel_s   = !cs_n_s && cs_s;
  assign sel_par = sel_s && par_s;
  assign sel_ser = sel_s && !par_s;

  logic       p_vld, s_vld, oe_p;
  hbus_xfer_t p_evt, s_evt, evt_q;
  logic [DW-1:0] dout_p;

  hbus_par u_par (
    .clk(clk), .rst_n(rst_n), .sel(sel_par), .m68(m68_s), .rs(rs_s),
    .en_rd(en_s), .rw_wr(rw_s), .db(db_s), .busy(busy), .rd_byte(rd_data),
    .evt_vld(p_vld), .evt(p_evt), .oe(oe_p), .dout(dout_p)
  );

  hbus_ser u_ser (
    .clk(clk), .rst_n(rst_n), .sel(sel_ser), .rs(rs_s),
    .sclk(db_s[DW-2]), .sdat(db_s[DW-1]), .busy(busy),
    .evt_vld(s_vld), .evt(s_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_vld <= 1'b0;
      evt_q    <= '0;
    end else begin
      xfer_vld <= par_s ? p_vld : s_vld;
      if (p_vld || s_vld) evt_q <= par_s ? p_evt : s_evt;
    end
  end

  assign xfer_byte = evt_q.dat;
  assign xfer_dc   = evt_q.dc;
  assign xfer_rd   = evt_q.rd;
  assign db_oe     = oe_p;
  assign db_out    = dout_p;

  // R1: a reported transfer was seen while selected
  a_r1_sel_only: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld |-> $past(sel_s));
  // R7: the serial path never reports a read
  a_r7_serial_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_vld && !$past(par_s)) |-> !xfer_rd);
  // R9: under busy only status reads get through
  a_r9_busy_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_vld && $past(busy)) |-> (xfer_rd && !xfer_dc));
  // R6: a status read carries zeros below the busy bit
  a_r6_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_vld && xfer_rd && !xfer_dc) |-> (xfer_byte[DW-2:0] == '0));
endmodule

// File: tb/host_bus_bridge_tb.sv
module host_bus_bridge_tb;
  localparam time CYC = 20ns;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, cs = 0, mode_par = 1, mode_68 = 1, rs = 0, en_rd = 0, rw_wr = 1;
  logic [7:0] db_in = 0, rd_data = 8'h00;
  logic busy = 0;
  logic [7:0] db_out, xfer_byte;
  logic db_oe, xfer_vld, xfer_dc, xfer_rd;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [9:0] exp_q[$];

  always #(CYC/2) clk = ~clk;

  host_bus_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs(cs), .mode_par(mode_par),
    .mode_68(mode_68), .rs(rs), .en_rd(en_rd), .rw_wr(rw_wr), .db_in(db_in),
    .db_out(db_out), .db_oe(db_oe), .busy(busy), .rd_data(rd_data),
    .xfer_vld(xfer_vld), .xfer_byte(xfer_byte), .xfer_dc(xfer_dc), .xfer_rd(xfer_rd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R10: every pulse must match a queued item, and each pulse lasts one cycle
  logic prev_vld = 0;
  always @(negedge clk) begin
    if (rst_n && xfer_vld) begin
      if (prev_vld) chk(0, "R10 pulse width", 2, 1);
      if (exp_q.size() == 0) begin
        chk(0, "R1/R9 unexpected transfer", {22'd0, xfer_byte, xfer_dc, xfer_rd}, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({xfer_byte, xfer_dc, xfer_rd} == e, "R2-R7 transfer",
            {22'd0, xfer_byte, xfer_dc, xfer_rd}, {22'd0, e});
      end
    end
    prev_vld = xfer_vld;
  end

  function automatic logic [9:0] item(input logic [7:0] b, input logic dc, input logic rd);
    return {b, dc, rd};
  endfunction

  task automatic wr68(input logic r, input logic [7:0] b, input bit expect_it);
    rs = r; rw_wr = 0; db_in = b; cyc(6);
    en_rd = 1; cyc(6);
    if (expect_it) exp_q.push_back(item(b, r, 0));
    en_rd = 0; cyc(6);
    rw_wr = 1; cyc(2);
  endtask

  task automatic rd68(input logic r, input logic [7:0] e, input bit expect_it, input bit exp_oe, input string req);
    rs = r; rw_wr = 1; cyc(6);
    if (expect_it) exp_q.push_back(item(e, r, 1));
    en_rd = 1; cyc(6);
    chk(db_oe == exp_oe, req, db_oe, exp_oe);
    if (exp_oe) chk(db_out == e, req, db_out, e);
    en_rd = 0; cyc(6);
    chk(db_oe == 0, req, db_oe, 0);
  endtask

  task automatic wr80(input logic r, input logic [7:0] b, input bit expect_it);
    rs = r; db_in = b; cyc(6);
    rw_wr = 0; cyc(6);
    if (expect_it) exp_q.push_back(item(b, r, 0));
    rw_wr = 1; cyc(6);
  endtask

  task automatic rd80(input logic r, input logic [7:0] e, input bit expect_it, input string req);
    rs = r; cyc(6);
    if (expect_it) exp_q.push_back(item(e, r, 1));
    en_rd = 0; cyc(6);
    chk(db_oe == 1, req, db_oe, 1);
    chk(db_out == e, req, db_out, e);
    en_rd = 1; cyc(6);
  endtask

  task automatic ser_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      db_in[7] = b[i]; db_in[6] = 0; cyc(3);
      db_in[6] = 1; cyc(3);
    end
    db_in[6] = 0; cyc(3);
  endtask

  task automatic select(input bit on);
    cs_n = !on; cs = on; cyc(6);
  endtask

  initial begin
    #(CYC * 100000);
    if (!finished) begin
      chk(0, "watchdog", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk(db_oe == 0 && xfer_vld == 0, "reset state", {db_oe, xfer_vld}, 0);
    rst_n = 1; cyc(6);
    chk(db_oe == 0 && xfer_vld == 0, "reset state after release", {db_oe, xfer_vld}, 0);

    // R1: 6800 bus activity while deselected
    wr68(1, 8'hA5, 0);
    rd68(1, 8'h00, 0, 0, "R1 no drive while deselected");
    cs_n = 0; cs = 0; cyc(6);
    wr68(0, 8'h11, 0);
    cs_n = 1; cs = 1; cyc(6);
    wr68(0, 8'h12, 0);

    // R2, R3, R6: 6800 style
    select(1);
    wr68(1, 8'h3C, 1);
    wr68(0, 8'hC3, 1);
    rd_data = 8'h5A;
    rd68(1, 8'h5A, 1, 1, "R3/R6 6800 data read");
    rd68(0, 8'h00, 1, 1, "R6 6800 status read");
    select(0);

    // R4, R5: 8080 style
    mode_68 = 0; en_rd = 1; rw_wr = 1; cyc(6);
    select(1);
    wr80(1, 8'h81, 1);
    wr80(0, 8'h7E, 1);
    rd_data = 8'hE7;
    rd80(1, 8'hE7, 1, "R5/R6 8080 data read");
    rd80(0, 8'h00, 1, "R5/R6 8080 status read");

    // R9: busy gating
    busy = 1; cyc(2);
    wr80(1, 8'h44, 0);
    rd80(1, 8'hE7, 0, "R9 data read under busy");
    rd80(0, 8'h80, 1, "R9 status read under busy");
    busy = 0; cyc(2);
    select(0);

    // R7: serial mode
    mode_par = 0; db_in = 0; cyc(6);
    select(1);
    rs = 1; cyc(4);
    exp_q.push_back(item(8'hB4, 1, 0));
    ser_bits(8'hB4, 8);
    rs = 0; cyc(4);
    exp_q.push_back(item(8'h2D, 0, 0));
    ser_bits(8'h2D, 8);
    // R7: parallel strobes ignored in serial mode, and no drive
    en_rd = 0; cyc(6);
    chk(db_oe == 0, "R7 no drive in serial", db_oe, 0);
    rw_wr = 0; cyc(6); rw_wr = 1; en_rd = 1; cyc(6);

    // R8: partial byte thrown away on deselect
    rs = 1; cyc(4);
    ser_bits(8'hFF, 3);
    select(0);
    select(1);
    exp_q.push_back(item(8'h0F, 1, 0));
    ser_bits(8'h0F, 8);

    // R9: serial write under busy
    busy = 1; cyc(2);
    ser_bits(8'h99, 8);
    busy = 0; cyc(10);

    chk(exp_q.size() == 0, "R2-R9 missing transfers", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule